// File: doc/BRIEF.md
# Serial Output Stream Advancement Unit

This block turns per-stream parallel bytes into a set of serial TDM output lines. All lines share one frame timebase, which restarts on a frame pulse. Within it, each line can have its bit edges pulled earlier by a small whole number of fast system-clock cycles. The amount is set per line through a bank of 16-bit control words. The shift is always shorter than one bit, so the shared frame structure does not move. Only the point at which each line changes state moves, by 0, 2, 4 or 6 clock periods. At a 131.072 MHz system clock these are roughly 15, 31 and 46 ns.

The line rate is one global selection of 2, 4, 8 or 16 Mbps and applies to every line. The frame always lasts the same number of system-clock cycles, so a slower rate carries fewer channels. Each line has a valid/ready byte input backed by a one-byte holding buffer. Ready is high whenever that buffer is empty, and the buffer empties when the byte it holds begins to go out. Holding valid low is back-pressure from the source side. If no byte is waiting when a channel starts, the line sends an all-ones idle byte rather than stalling. The rate select is treated as static and is changed only while reset is held.

Top module: `tdm_adv_serializer`

## Requirements
- R1: There is one control word per stream, addressed 0 to NUM_STREAMS-1. Every word resets to 0. A read returns the addressed word combinationally in the same cycle, and a write lands on the next clock edge.
- R2: Bits 1:0 of a control word choose the advancement: code 0 is none, and codes 1, 2 and 3 pull the edges 2, 4 and 6 cycles earlier.
- R3: Bits 15:2 of a control word have no effect on the output timing and always read back as 0, whatever was written to them.
- R4: A frame lasts 2^(BIT_LOG2_MIN+3+CH_LOG2) cycles. The cycle in which frame_pulse_i is high is frame position 0, and the position then counts up and wraps by itself. With code 0, the MSB of channel 0 is on the line from the cycle after position 0.
- R5: rate_sel_i values 0, 1, 2 and 3 select 2, 4, 8 and 16 Mbps. A bit then lasts 2^BIT_LOG2_MIN shifted left by (3 - rate_sel_i) cycles, and a frame carries 2^CH_LOG2 shifted right by (3 - rate_sel_i) channels.
- R6: With code c, every bit transition on that line comes exactly 2c cycles earlier than with code 0. Channel 0 of a frame therefore starts 2c cycles before that frame's position 0.
- R7: A newly written code leaves the line's timing unchanged until the next frame position 0 and governs from the cycle after it. Every channel's byte is still sent exactly once.
- R8: Bytes are sent MSB first, one byte per channel, and the channels of a frame follow in order from 0 upward.
- R9: in_ready_o[s] is high exactly when stream s's holding buffer is empty, and a byte is taken on a cycle with valid and ready both high. The buffer empties in the cycle the channel's first bit is launched, so ready is high in the following cycle. A byte taken in a launch cycle that found the buffer empty goes to the following channel.
- R10: Each line is 1 after reset until its first launch. A channel whose launch finds the buffer empty is sent as 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_pulse_i | input | 1 | Marks frame position 0 |
| rate_sel_i | input | 2 | Global line rate: 0=2, 1=4, 2=8, 3=16 Mbps |
| in_valid_i | input | NUM_STREAMS | Per-stream byte valid |
| in_ready_o | output | NUM_STREAMS | Per-stream holding buffer empty |
| in_data_i | input | 8*NUM_STREAMS | Per-stream byte, stream s in bits 8s+7:8s |
| cfg_wr_en_i | input | 1 | Control word write strobe |
| cfg_wr_addr_i | input | log2(NUM_STREAMS) | Control word write index |
| cfg_wr_data_i | input | 16 | Control word write value |
| cfg_rd_addr_i | input | log2(NUM_STREAMS) | Control word read index |
| cfg_rd_data_o | output | 16 | Control word read value |
| sdo_o | output | NUM_STREAMS | Serial output lines |

## Verification
Two events can land on the same clock edge: a channel launch, and a byte arriving from the source. The first launch after reset always finds every buffer empty while valid is already high, so that edge provokes the collision. The bench judges it by expecting 8'hFF on channel 0 of the first frame, followed by the first byte offered on channel 1. It then keeps that one-launch offset through every later frame, under every code and at all four rates. A register write placed mid-frame is checked against the old timing for the rest of that frame and against the new timing from the next frame.

// File: rtl/tdm_adv_pkg.sv
package tdm_adv_pkg;
  typedef logic [1:0] adv_code_t;

  typedef enum logic [1:0] {
    RATE_2M  = 2'd0,
    RATE_4M  = 2'd1,
    RATE_8M  = 2'd2,
    RATE_16M = 2'd3
  } rate_e;

  localparam int unsigned CODE_W = 2;
  localparam int unsigned BYTE_W = 8;
  localparam logic [BYTE_W-1:0] IDLE_BYTE = '1;
endpackage

// File: rtl/tdm_adv_timer.sv
module tdm_adv_timer #(
  parameter int unsigned FW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_pulse_i,
  output logic [FW-1:0] pos_o,
  output logic          frame_start_o
);
  logic [FW-1:0] cnt_q;

  // The pulse forces position 0; otherwise the counter free-runs and wraps on its width.
  assign pos_o         = frame_pulse_i ? '0 : cnt_q;
  assign frame_start_o = (pos_o == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= pos_o + FW'(1);
  end

  a_r4_pulse_restarts_count: assert property (@(posedge clk) disable iff (!rst_n)
    frame_pulse_i |=> (pos_o == FW'(1)) || frame_pulse_i);
endmodule

// File: rtl/tdm_adv_regs.sv
module tdm_adv_regs
  import tdm_adv_pkg::*;
#(
  parameter int unsigned NUM_STREAMS = 32,
  parameter int unsigned AW          = 5
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en_i,
  input  logic [AW-1:0]                 wr_addr_i,
  input  logic [CODE_W-1:0]             wr_code_i,
  input  logic [AW-1:0]                 rd_addr_i,
  output logic [CODE_W-1:0]             rd_code_o,
  input  logic                          frame_start_i,
  output logic [NUM_STREAMS-1:0][CODE_W-1:0] act_o
);
  logic [NUM_STREAMS-1:0][CODE_W-1:0] cfg_q;

  // Only the code field is stored; the reserved field has no flops at all.
  always_ff @(posedge clk) begin
    if (!rst_n) cfg_q <= '0;
    else if (wr_en_i && (int'(wr_addr_i) < NUM_STREAMS)) cfg_q[wr_addr_i] <= wr_code_i;
  end

  // Shadow copy that the lanes use, refreshed only on frame position 0.
  always_ff @(posedge clk) begin
    if (!rst_n)             act_o <= '0;
    else if (frame_start_i) act_o <= cfg_q;
  end

  always_comb begin
    rd_code_o = '0;
    if (int'(rd_addr_i) < NUM_STREAMS) rd_code_o = cfg_q[rd_addr_i];
  end

  a_r7_commit_only_at_frame_start: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_o) |-> $past(frame_start_i));
endmodule

// File: rtl/tdm_adv_lane.sv
module tdm_adv_lane
  import tdm_adv_pkg::*;
#(
  parameter int unsigned FW           = 14,
  parameter int unsigned BIT_LOG2_MIN = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FW-1:0]     pos_i,
  input  logic [1:0]        rate_i,
  input  logic [CODE_W-1:0] adv_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [BYTE_W-1:0] in_data_i,
  output logic              sdo_o
);
  logic [FW-1:0]     q_pos;
  logic [FW-1:0]     bit_mask;
  logic [2:0]        bit_idx;
  int unsigned       sh;
  logic              launch;
  logic              first;
  logic [BYTE_W-1:0] shreg_q;
  logic [BYTE_W-1:0] hold_q;
  logic              full_q;

  // Shifted position: the lane behaves as if it were 2*code cycles later in the frame.
  always_comb begin
    sh       = BIT_LOG2_MIN + 3 - int'(rate_i);
    q_pos    = pos_i + FW'({adv_i, 1'b0});
    bit_mask = (FW'(1) << sh) - FW'(1);
    bit_idx  = 3'(q_pos >> sh);
    launch   = ((q_pos & bit_mask) == '0);
    first    = launch && (bit_idx == 3'd0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      shreg_q <= IDLE_BYTE;
    else if (first)  shreg_q <= full_q ? hold_q : IDLE_BYTE;
    else if (launch) shreg_q <= {shreg_q[BYTE_W-2:0], 1'b1};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      hold_q <= '0;
    end else begin
      if (first) full_q <= 1'b0;
      if (in_valid_i && !full_q) begin
        hold_q <= in_data_i;
        full_q <= 1'b1;
      end
    end
  end

  assign in_ready_o = !full_q;
  assign sdo_o      = shreg_q[BYTE_W-1];

  a_r8_line_moves_only_after_launch: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdo_o) |-> $past(launch));
  a_r9_ready_falls_only_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_ready_o) |-> $past(in_valid_i));
  a_r9_ready_after_loaded_launch: assert property (@(posedge clk) disable iff (!rst_n)
    (first && full_q) |=> in_ready_o);
  a_r10_empty_launch_idles_high: assert property (@(posedge clk) disable iff (!rst_n)
    (first && !full_q) |=> sdo_o);
endmodule

// File: rtl/tdm_adv_serializer.sv
module tdm_adv_serializer
  import tdm_adv_pkg::*;
#(
  parameter int unsigned NUM_STREAMS  = 32,
  parameter int unsigned BIT_LOG2_MIN = 3,
  parameter int unsigned CH_LOG2      = 8,
  parameter int unsigned REG_W        = 16,
  localparam int unsigned AW          = (NUM_STREAMS > 1) ? $clog2(NUM_STREAMS) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          frame_pulse_i,
  input  logic [1:0]                    rate_sel_i,
  input  logic [NUM_STREAMS-1:0]        in_valid_i,
  output logic [NUM_STREAMS-1:0]        in_ready_o,
  input  logic [NUM_STREAMS*BYTE_W-1:0] in_data_i,
  input  logic                          cfg_wr_en_i,
  input  logic [AW-1:0]                 cfg_wr_addr_i,
  input  logic [REG_W-1:0]              cfg_wr_data_i,
  input  logic [AW-1:0]                 cfg_rd_addr_i,
  output logic [REG_W-1:0]              cfg_rd_data_o,
  output logic [NUM_STREAMS-1:0]        sdo_o
);
  // CH_LOG2 must be at least 3 so the slowest rate still carries one channel.
  localparam int unsigned FW = BIT_LOG2_MIN + 3 + CH_LOG2;

  logic [FW-1:0]                      pos;
  logic                               frame_start;
  logic [NUM_STREAMS-1:0][CODE_W-1:0] act;
  logic [CODE_W-1:0]                  rd_code;

  tdm_adv_timer #(.FW(FW)) u_timer (
    .clk           (clk),
    .rst_n         (rst_n),
    .frame_pulse_i (frame_pulse_i),
    .pos_o         (pos),
    .frame_start_o (frame_start)
  );

  tdm_adv_regs #(.NUM_STREAMS(NUM_STREAMS), .AW(AW)) u_regs (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en_i       (cfg_wr_en_i),
    .wr_addr_i     (cfg_wr_addr_i),
    .wr_code_i     (cfg_wr_data_i[CODE_W-1:0]),
    .rd_addr_i     (cfg_rd_addr_i),
    .rd_code_o     (rd_code),
    .frame_start_i (frame_start),
    .act_o         (act)
  );

  assign cfg_rd_data_o = {{(REG_W-CODE_W){1'b0}}, rd_code};

  for (genvar g = 0; g < NUM_STREAMS; g++) begin : g_lane
    tdm_adv_lane #(.FW(FW), .BIT_LOG2_MIN(BIT_LOG2_MIN)) u_lane (
      .clk        (clk),
      .rst_n      (rst_n),
      .pos_i      (pos),
      .rate_i     (rate_sel_i),
      .adv_i      (act[g]),
      .in_valid_i (in_valid_i[g]),
      .in_ready_o (in_ready_o[g]),
      .in_data_i  (in_data_i[g*BYTE_W +: BYTE_W]),
      .sdo_o      (sdo_o[g])
    );
  end
endmodule

// File: tb/tdm_adv_serializer_bench.sv
module tdm_adv_serializer_bench;
  localparam int NS     = 4;
  localparam int BLM    = 3;
  localparam int CHL    = 3;
  localparam int AW     = 2;
  localparam int FRAME  = 1 << (BLM + 3 + CHL);
  localparam int MAXCH  = 1 << CHL;
  localparam int NFRM   = 5;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              fp = 1'b0;
  logic [1:0]        rate = 2'd0;
  logic [NS-1:0]     in_valid = '1;
  logic [NS-1:0]     in_ready;
  logic [NS*8-1:0]   in_data = '0;
  logic              wr_en = 1'b0;
  logic [AW-1:0]     wr_addr = '0;
  logic [15:0]       wr_data = '0;
  logic [AW-1:0]     rd_addr = '0;
  logic [15:0]       rd_data;
  logic [NS-1:0]     sdo;

  int nchk = 0;
  int nfail = 0;
  int t;
  int acc[NS];
  bit pend[NS];
  int cfg[NS];
  int act[NS];
  bit se_bad[NS];
  int se_a[NS], se_e[NS];
  bit re_bad[NS];
  int re_a[NS], re_e[NS];

  always #4 clk = ~clk;

  tdm_adv_serializer #(.NUM_STREAMS(NS), .BIT_LOG2_MIN(BLM), .CH_LOG2(CHL)) u_tdm_adv_serializer (
    .clk(clk), .rst_n(rst_n), .frame_pulse_i(fp), .rate_sel_i(rate),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_data_i(in_data),
    .cfg_wr_en_i(wr_en), .cfg_wr_addr_i(wr_addr), .cfg_wr_data_i(wr_data),
    .cfg_rd_addr_i(rd_addr), .cfg_rd_data_o(rd_data), .sdo_o(sdo)
  );

  function automatic logic [7:0] data_of(int s, int k);
    return 8'((k * 29 + s * 53 + 7) % 128);
  endfunction

  function automatic int bitlen(int r);
    return (1 << BLM) << (3 - r);
  endfunction

  // Expected line value in cycle tt for advancement a cycles.
  function automatic bit exp_sdo(int s, int tt, int a, int r);
    int b, u, qq, ch, bi, lidx;
    logic [7:0] by;
    if (tt < 1) return 1'b1;
    b = bitlen(r);
    u = tt - 1 + a;
    qq = u % FRAME;
    ch = qq / (8 * b);
    bi = (qq / b) % 8;
    lidx = (u / FRAME) * (MAXCH >> (3 - r)) + ch;
    if (lidx == 0) return 1'b1;
    by = data_of(s, lidx - 1);
    return by[7 - bi];
  endfunction

  function automatic bit exp_rdy(int tt, int a, int r);
    int u;
    if (tt < 1) return 1'b1;
    u = tt - 1 + a;
    return ((u % (8 * bitlen(r))) == 0) && ((u / (8 * bitlen(r))) >= 1);
  endfunction

  task automatic check(bit ok, string tag, int actv, int expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, actv, expv);
    end
  endtask

  task automatic start_cycle();
    @(posedge clk);
    #1;
    t++;
    for (int s = 0; s < NS; s++) begin
      if (pend[s]) acc[s]++;
      pend[s] = 1'b0;
      in_data[s*8 +: 8] = data_of(s, acc[s]);
    end
    fp = ((t % FRAME) == 0);
    wr_en = 1'b0;
    if ((t % FRAME) == 1) for (int s = 0; s < NS; s++) act[s] = cfg[s];
  endtask

  task automatic do_reset(int r);
    rst_n = 1'b0;
    rate = 2'(r);
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    t = 0;
    fp = 1'b1;
    for (int s = 0; s < NS; s++) begin
      acc[s] = 0; pend[s] = 1'b0; cfg[s] = 0; act[s] = 0;
      se_bad[s] = 1'b0; re_bad[s] = 1'b0;
      in_data[s*8 +: 8] = data_of(s, 0);
    end
  endtask

  task automatic run_rate(int r);
    int pos, fr, b, code;
    string tag;
    do_reset(r);
    b = bitlen(r);
    for (int cyc = 0; cyc < NFRM * FRAME; cyc++) begin
      if (cyc > 0) start_cycle();
      pos = t % FRAME;
      fr = t / FRAME;
      if ((fr == 1 || fr == 3) && pos >= FRAME / 2 && pos < FRAME / 2 + NS) begin
        int s;
        s = pos - FRAME / 2;
        code = (fr == 1) ? ((s + r) % 4) : ((s * 3 + r + 1) % 4);
        wr_en = 1'b1;
        wr_addr = AW'(s);
        wr_data = (s % 2 == 1) ? {14'h3FFF, 2'(code)} : {14'h0, 2'(code)};
        cfg[s] = code;
      end
      if ((fr == 0 || fr == 2) && pos >= 3 && pos < 3 + NS) rd_addr = AW'(pos - 3);
      @(negedge clk);
      if ((fr == 0 || fr == 2) && pos >= 3 && pos < 3 + NS) begin
        if (fr == 0) check(rd_data == 16'h0, $sformatf("R1 reset readback s%0d", pos - 3), rd_data, 0);
        else check(rd_data == 16'(cfg[pos - 3]), $sformatf("R1 R3 readback s%0d", pos - 3),
                   rd_data, cfg[pos - 3]);
      end
      if (fr == 0 || pos > b) begin
        for (int s = 0; s < NS; s++) begin
          bit es, er;
          es = exp_sdo(s, t, 2 * act[s], r);
          er = exp_rdy(t, 2 * act[s], r);
          if (sdo[s] !== es && !se_bad[s]) begin se_bad[s] = 1'b1; se_a[s] = sdo[s]; se_e[s] = es; end
          if (in_ready[s] !== er && !re_bad[s]) begin re_bad[s] = 1'b1; re_a[s] = in_ready[s]; re_e[s] = er; end
        end
      end
      for (int s = 0; s < NS; s++) pend[s] = in_ready[s] && in_valid[s];
      if (pos == FRAME - 1) begin
        for (int s = 0; s < NS; s++) begin
          if (fr == 0) tag = "R10 R4 R8";
          else if (fr == 1 || fr == 3) tag = "R7 R3 R6";
          else tag = "R2 R5 R6 R8";
          check(!se_bad[s], $sformatf("%s line rate%0d frame%0d s%0d", tag, r, fr, s), se_a[s], se_e[s]);
          check(!re_bad[s], $sformatf("R9 ready rate%0d frame%0d s%0d", r, fr, s), re_a[s], re_e[s]);
          se_bad[s] = 1'b0;
          re_bad[s] = 1'b0;
        end
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL R4 watchdog actual=hang expected=finish");
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

  initial begin
    t = 0;
    for (int r = 0; r < 4; r++) run_rate(r);
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end
endmodule